// File: doc/BRIEF.md
# Variable-Width Byte-Lane FIFO Access Port

This block is the processor-facing window onto a byte-organised data queue, the kind that sits behind an endpoint buffer of a serial bus controller. Software writes outgoing bytes into the queue, or reads incoming bytes out of it, through a single 32-bit data port. A two-bit width selector sets how many bytes each access moves: one, two or four. A byte-order select sets which lanes of the 32-bit bus carry which queue positions. It also sets which lanes are live and which are ignored.

Every access is gated by a ready indication. A write is ready only when the queue has room for the whole access. A read is ready only when the queue holds enough bytes for it. An access that is not ready changes nothing. The queue depth is a parameter. The current byte count is visible, and a synchronous clear input empties the queue.

Top module: `bytelane_fifo_port`

## Requirements
- R1: After reset the queue is empty. byte_count is 0, rd_data is 0, rd_ready is 0 and wr_ready is 1 for any valid width.
- R2: width_sel 2'b00 moves 1 byte, 2'b01 moves 2 bytes and 2'b10 moves 4 bytes per access. 2'b11 is reserved. With 2'b11, wr_ready and rd_ready are both 0 and neither access has any effect.
- R3: An accepted write pushes bytes k = 0 up to n-1 in that order. With big_end = 0, byte k is taken from bus bits [8k+7:8k]. With big_end = 1, it is taken from bits [8(3-k)+7:8(3-k)].
- R4: Write data on lanes outside the selected width is ignored and never reaches the queue.
- R5: An accepted read pops n bytes. Queue byte k (head = 0) is placed on the lane given by the same mapping as R3. All other lanes read as 0.
- R6: wr_ready is 1 exactly when the free space (DEPTH - byte_count) is at least the access width in bytes. rd_ready is 1 exactly when byte_count is at least the access width in bytes.
- R7: A write or read presented while its ready flag is 0 leaves the queue and byte_count unchanged. rd_data is 0 whenever no read is being accepted.
- R8: byte_count always equals the bytes held and never exceeds DEPTH. A write and a read of the same width accepted in the same cycle are both performed, and the net count change is zero.
- R9: clr empties the queue on the next clock edge and overrides any write or read in the same cycle.
- R10: Byte order is first-in first-out across mixed widths and byte orders, including when the storage pointers wrap past the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous queue clear, priority over accesses |
| width_sel | input | 2 | Access width: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 reserved |
| big_end | input | 1 | Lane order select: 0 = byte 0 on the low lane, 1 = byte 0 on the high lane |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data bus |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data bus, zero when no read is accepted |
| wr_ready | output | 1 | Write can be accepted at the current width |
| rd_ready | output | 1 | Read can be accepted at the current width |
| byte_count | output | $clog2(DEPTH+1) | Bytes currently held |

## Verification
A push and a pop can fall in the same cycle, and so can a clear and an access. The bench brings the queue to two free bytes and drives a 16-bit write and a 16-bit read together. It checks that the head bytes appear on the read lanes, that the count stays put and that the written bytes surface later, after the pointers wrap. It also asserts clear together with a write and expects an empty queue on the next cycle.

// File: rtl/blp_pkg.sv
package blp_pkg;

    localparam int LANES = 4;

    typedef logic [7:0] byte_t;
    typedef byte_t [LANES-1:0] lane_vec_t;

    typedef enum logic [1:0] {
        ACC_B8   = 2'b00,
        ACC_B16  = 2'b01,
        ACC_B32  = 2'b10,
        ACC_RSVD = 2'b11
    } acc_width_e;

    // Bytes moved by one access; zero for the reserved code.
    function automatic logic [2:0] acc_bytes(input acc_width_e w);
        case (w)
            ACC_B8:  return 3'd1;
            ACC_B16: return 3'd2;
            ACC_B32: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Bus lane that carries queue byte k for the chosen byte order.
    function automatic int unsigned lane_for(input int unsigned k, input logic big);
        return big ? (LANES - 1 - k) : k;
    endfunction

endpackage

// File: rtl/blp_lane_gather.sv
module blp_lane_gather
    import blp_pkg::*;
(
    input  logic [31:0] bus_i,
    input  logic        big_i,
    output lane_vec_t   bytes_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign bytes_o[k] = big_i ? bus_i[8*(LANES-1-k) +: 8] : bus_i[8*k +: 8];
    end
endmodule

// File: rtl/blp_lane_scatter.sv
module blp_lane_scatter
    import blp_pkg::*;
(
    input  lane_vec_t   bytes_i,
    input  logic [2:0]  nbytes_i,
    input  logic        big_i,
    input  logic        en_i,
    output logic [31:0] bus_o
);
    always_comb begin
        bus_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (en_i && (k < int'(nbytes_i))) begin
                bus_o[8*lane_for(k, big_i) +: 8] = bytes_i[k];
            end
        end
    end
endmodule

// File: rtl/blp_byte_ring.sv
module blp_byte_ring
    import blp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            push,
    input  logic [2:0]      push_n,
    input  lane_vec_t       din,
    input  logic            pop,
    input  logic [2:0]      pop_n,
    output lane_vec_t       dout,
    output logic [CNTW-1:0] count
);
    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;
    logic [CNTW-1:0] add_n;
    logic [CNTW-1:0] sub_n;

    assign add_n = push ? CNTW'(push_n) : '0;
    assign sub_n = pop  ? CNTW'(pop_n)  : '0;

    for (genvar k = 0; k < LANES; k++) begin : g_head
        assign dout[k] = mem[rp + AW'(k)];
    end

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(push_n)) begin
                    mem[wp + AW'(k)] <= din[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(add_n);
            rp    <= rp + AW'(sub_n);
            count <= count + add_n - sub_n;
        end
    end
endmodule

// File: rtl/bytelane_fifo_port.sv
module bytelane_fifo_port
    import blp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [1:0]      width_sel,
    input  logic            big_end,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    input  logic            rd_en,
    output logic [31:0]     rd_data,
    output logic            wr_ready,
    output logic            rd_ready,
    output logic [CNTW-1:0] byte_count
);
    logic [2:0]      nbytes;
    logic [CNTW-1:0] need;
    logic [CNTW-1:0] free_bytes;
    logic            do_push;
    logic            do_pop;
    lane_vec_t       wr_bytes;
    lane_vec_t       head_bytes;

    assign nbytes     = acc_bytes(acc_width_e'(width_sel));
    assign need       = CNTW'(nbytes);
    assign free_bytes = CNTW'(DEPTH) - byte_count;
    assign wr_ready   = (nbytes != 3'd0) && (free_bytes >= need);
    assign rd_ready   = (nbytes != 3'd0) && (byte_count >= need);
    assign do_push    = wr_en && wr_ready;
    assign do_pop     = rd_en && rd_ready;

    blp_lane_gather u_gather (
        .bus_i   (wr_data),
        .big_i   (big_end),
        .bytes_o (wr_bytes)
    );

    blp_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .push   (do_push),
        .push_n (nbytes),
        .din    (wr_bytes),
        .pop    (do_pop),
        .pop_n  (nbytes),
        .dout   (head_bytes),
        .count  (byte_count)
    );

    blp_lane_scatter u_scatter (
        .bytes_i  (head_bytes),
        .nbytes_i (nbytes),
        .big_i    (big_end),
        .en_i     (do_pop),
        .bus_o    (rd_data)
    );
endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic [1:0]      width_sel,
    input logic            wr_en,
    input logic            rd_en,
    input logic [31:0]     rd_data,
    input logic            wr_ready,
    input logic            rd_ready,
    input logic [CNTW-1:0] byte_count
);
    logic [CNTW-1:0] nb;
    logic            acc_w;
    logic            acc_r;

    always_comb begin
        case (width_sel)
            2'b00:   nb = CNTW'(1);
            2'b01:   nb = CNTW'(2);
            2'b10:   nb = CNTW'(4);
            default: nb = '0;
        endcase
    end

    assign acc_w = wr_en && wr_ready;
    assign acc_r = rd_en && rd_ready;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        byte_count <= CNTW'(DEPTH)); // R8

    AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (rst)
        (acc_w && !acc_r && !clr) |=> byte_count == $past(byte_count) + $past(nb)); // R3

    AST_READ_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (acc_r && !acc_w && !clr) |=> byte_count == $past(byte_count) - $past(nb)); // R5

    AST_BOTH_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_r && acc_w && !clr) |=> $stable(byte_count)); // R8

    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!acc_r && !acc_w && !clr) |=> $stable(byte_count)); // R7

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !acc_r |-> rd_data == 32'h0); // R7

    AST_RESERVED_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (width_sel == 2'b11) |-> (!wr_ready && !rd_ready)); // R2

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> byte_count == '0); // R9
endmodule

bind bytelane_fifo_port blp_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_bytelane_fifo_port.sv
module tb_bytelane_fifo_port;

    localparam int DEPTH = 64;
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clr = 1'b0;
    logic [1:0]      width_sel = 2'b00;
    logic            big_end = 1'b0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            rd_en = 1'b0;
    logic [31:0]     rd_data;
    logic            wr_ready;
    logic            rd_ready;
    logic [CNTW-1:0] byte_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bytelane_fifo_port #(.DEPTH(DEPTH)) dut (.*);

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  w;
        logic        be;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [7:0]  exp_cnt;
    } vec_t;

    // Queue after writes: 11 22 33 44 AA BB 77 99
    localparam vec_t VEC [8] = '{
        '{1'b0, 2'b10, 1'b0, 32'h4433_2211, 32'h0, 8'd4},  // R3 32-bit LE
        '{1'b0, 2'b01, 1'b1, 32'hAABB_CCDD, 32'h0, 8'd6},  // R3 R4 16-bit BE
        '{1'b0, 2'b00, 1'b0, 32'h1234_5677, 32'h0, 8'd7},  // R4 8-bit LE
        '{1'b0, 2'b00, 1'b1, 32'h99FF_FFFF, 32'h0, 8'd8},  // R4 8-bit BE
        '{1'b1, 2'b10, 1'b1, 32'h0, 32'h1122_3344, 8'd4},  // R5 32-bit BE
        '{1'b1, 2'b00, 1'b0, 32'h0, 32'h0000_00AA, 8'd3},  // R5 8-bit LE
        '{1'b1, 2'b01, 1'b0, 32'h0, 32'h0000_77BB, 8'd1},  // R5 16-bit LE
        '{1'b1, 2'b00, 1'b1, 32'h0, 32'h9900_0000, 8'd0}   // R5 8-bit BE
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One access cycle; rd_data and ready flags are captured before the edge.
    task automatic access(input logic do_w, input logic do_r, input logic [1:0] w,
                          input logic be, input logic [31:0] d, input logic c,
                          output logic [31:0] rd_v, output logic wr_rdy, output logic rd_rdy);
        @(negedge clk);
        width_sel = w;
        big_end   = be;
        wr_en     = do_w;
        rd_en     = do_r;
        wr_data   = d;
        clr       = c;
        #1;
        rd_v   = rd_data;
        wr_rdy = wr_ready;
        rd_rdy = rd_ready;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        clr   = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic        wrr;
        logic        rdr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 count", 32'(byte_count), 32'd0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 rd_ready", 32'(rd_ready), 32'd0);
        chk("R1 wr_ready", 32'(wr_ready), 32'd1);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            access(!VEC[i].is_rd, VEC[i].is_rd, VEC[i].w, VEC[i].be, VEC[i].data, 1'b0,
                   rv, wrr, rdr);
            if (VEC[i].is_rd) chk("R5 read lanes", rv, VEC[i].exp_rd);
            chk("R8 count", 32'(byte_count), 32'(VEC[i].exp_cnt));
        end

        // R7: read from empty queue
        access(1'b0, 1'b1, 2'b10, 1'b0, 32'h0, 1'b0, rv, wrr, rdr);
        chk("R7 empty read ready", 32'(rdr), 32'd0);
        chk("R7 empty read data", rv, 32'h0);
        chk("R7 empty read count", 32'(byte_count), 32'd0);

        // R2: reserved width
        access(1'b1, 1'b0, 2'b11, 1'b0, 32'hDEAD_BEEF, 1'b0, rv, wrr, rdr);
        chk("R2 reserved wr_ready", 32'(wrr), 32'd0);
        chk("R2 reserved rd_ready", 32'(rdr), 32'd0);
        chk("R2 reserved count", 32'(byte_count), 32'd0);

        // Fill with bytes 0..63 in order
        for (int i = 0; i < DEPTH / 4; i++) begin
            access(1'b1, 1'b0, 2'b10, 1'b0,
                   {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, 1'b0, rv, wrr, rdr);
        end
        chk("R8 full count", 32'(byte_count), 32'd64);

        // R6 / R7: full queue refuses even one byte
        access(1'b1, 1'b0, 2'b00, 1'b0, 32'h0000_00EE, 1'b0, rv, wrr, rdr);
        chk("R6 full wr_ready", 32'(wrr), 32'd0);
        chk("R7 full write ignored", 32'(byte_count), 32'd64);

        // Pop 2 bytes -> 62
        access(1'b0, 1'b1, 2'b01, 1'b0, 32'h0, 1'b0, rv, wrr, rdr);
        chk("R5 16-bit read", rv, 32'h0000_0100);

        // R6 boundary at two free bytes
        @(negedge clk);
        width_sel = 2'b10;
        #1;
        chk("R6 wr_ready 4 of 2 free", 32'(wr_ready), 32'd0);
        width_sel = 2'b01;
        #1;
        chk("R6 wr_ready 2 of 2 free", 32'(wr_ready), 32'd1);

        // R8: push and pop in the same cycle
        access(1'b1, 1'b1, 2'b01, 1'b0, 32'h5555_BEEF, 1'b0, rv, wrr, rdr);
        chk("R8 simultaneous read data", rv, 32'h0000_0302);
        chk("R8 simultaneous count", 32'(byte_count), 32'd62);

        // R10: drain in order across wrap
        for (int j = 0; j < 15; j++) begin
            access(1'b0, 1'b1, 2'b10, 1'b0, 32'h0, 1'b0, rv, wrr, rdr);
            chk("R10 ordered drain", rv,
                {8'(4*j+7), 8'(4*j+6), 8'(4*j+5), 8'(4*j+4)});
        end
        chk("R8 count after drain", 32'(byte_count), 32'd2);

        @(negedge clk);
        width_sel = 2'b10;
        #1;
        chk("R6 rd_ready 4 of 2 held", 32'(rd_ready), 32'd0);

        access(1'b0, 1'b1, 2'b01, 1'b0, 32'h0, 1'b0, rv, wrr, rdr);
        chk("R10 wrapped bytes", rv, 32'h0000_BEEF);
        chk("R8 empty again", 32'(byte_count), 32'd0);

        // R9: clear overrides a write
        access(1'b1, 1'b0, 2'b10, 1'b0, 32'h0102_0304, 1'b0, rv, wrr, rdr);
        chk("R9 pre-clear count", 32'(byte_count), 32'd4);
        access(1'b1, 1'b0, 2'b10, 1'b0, 32'h0506_0708, 1'b1, rv, wrr, rdr);
        chk("R9 clear count", 32'(byte_count), 32'd0);
        @(negedge clk);
        width_sel = 2'b00;
        #1;
        chk("R9 rd_ready after clear", 32'(rd_ready), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule